// File: doc/BRIEF.md
# Mass-Storage Adapter Control and Interrupt Logic

This block is the register side of a mass-storage bus adapter. A host reads and writes seven 16-bit registers through a simple port with byte-lane enables. The registers are a main control word, a secondary status word, an auxiliary word, the transfer word count, the bus address, a 6-bit address extension and a data buffer. The drive side supplies a completion pulse, an exception pulse, an attention level and a flag that says whether the selected drive exists. In return the block issues a one-cycle command strobe with the function code and the selected unit number.

A two-state sequencer tracks whether the adapter is idle or has a data transfer in flight. The state names and transitions are:

- State `ST_READY`: the ready flag (DONE) reads 1.
- State `ST_XFER`: DONE reads 0.
- Transition ACCEPT, from `ST_READY` to `ST_XFER`: a transfer command is accepted.
- Transition FINISH, from `ST_XFER` to `ST_READY`: the drive pulses completion.
- Transition FAULT, from `ST_XFER` to `ST_READY`: the drive pulses an exception, which also latches the transfer-error flag.
- Transition CLEAR, from either state to `ST_READY`: a controller clear.

The interrupt request combines two sources:

- An edge-sensitive latch. A host write can set it, and it samples the enable bit when DONE rises. Clearing the enable bit does not drop it.
- A level term formed from special-condition AND DONE AND enable. Clearing the enable bit drops it.

Top module: `stor_adapter_csr`

Register addresses on `reg_addr`: 0 control, 1 count, 2 address, 3 status, 4 data buffer, 5 extension, 6 auxiliary; 7 reads zero.

Control word layout:

| Bits | Field |
|------|-------|
| 0 | GO |
| 5:1 | function code (reads 0) |
| 6 | IE (enable) |
| 7 | DONE |
| 9:8 | extension low bits |
| 14 | TRE (transfer error) |
| 15 | SC (special condition) |

Status word layout:

| Bits | Field |
|------|-------|
| 2:0 | unit |
| 3 | address inhibit |
| 4 | parity test |
| 5 | clear (write only, reads 0) |
| 6 | input ready (always 1) |
| 7 | output ready (always 1) |
| 9 | missed-transfer error (writable) |
| 10 | program error |
| 12 | missing-drive error |
| 13 | parity error (writable) |

The status error field is bits 15:8. The auxiliary word holds IE in bit 6 and four writable bits in 3:0.

## Requirements
- R1: After reset the control word reads 0x0080 (DONE only), status reads 0x00C0, every other register reads 0, and `irq` is low.
- R2: A control write with byte lane 0 enabled and both bit 7 and bit 6 set sets the interrupt latch, so `irq` rises one cycle later.
- R3: When DONE goes from 0 to 1, the interrupt latch is loaded with the IE value held just before; a latch set earlier is therefore cleared if IE was 0.
- R4: `irq_ack`, a controller clear and reset each clear both the interrupt latch and IE.
- R5: `irq` equals latch OR (SC AND DONE AND IE); clearing IE removes the level term but not a latched request.
- R6: Any status error bit (15:8) or a latched TRE forces TRE and SC to read 1; `drv_attn` high forces SC to read 1.
- R7: A control write with lane 1 enabled and bit 14 set clears TRE and all status error bits.
- R8: GO with function code (bits 5:1) of 20 or more is a transfer. While DONE is 0 it sets program error (status bit 10) and issues no command. With `drv_present` low, any GO sets missing-drive (status bit 12) and issues no command. Otherwise `cmd_go` pulses for one cycle with `cmd_fn`; an accepted transfer clears TRE, the error bits and DONE.
- R9: Control bits 9:8 mirror extension bits 1:0. A control lane-1 write updates them only while DONE is 1. A write to the extension register with lane 0 loads all six bits; a lane-1-only write there has no effect.
- R10: IE is shared: writing it through the control word (lane 0) or the auxiliary word (lane 0) changes the value read from both.
- R11: Status always reads bits 7:6 as 1. Unit, inhibit, parity-test, missed-transfer and parity-error bits are writable. A lane-0 write with bit 5 set returns every register to the R1 state instead of storing.
- R12: Bit 0 of the address register always reads 0.
- R13: Count, address and data-buffer writes update only the enabled byte lanes and keep the other byte.
- R14: In `ST_XFER`, `drv_done` or `drv_exc` returns DONE to 1 in the next cycle; `drv_exc` also latches TRE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system init |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte-lane enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| drv_done | input | 1 | Drive completion pulse |
| drv_attn | input | 1 | Drive attention level |
| drv_exc | input | 1 | Drive exception pulse |
| drv_present | input | 1 | Selected drive exists |
| drv_unit | output | 3 | Selected unit number |
| cmd_go | output | 1 | One-cycle command strobe |
| cmd_fn | output | 5 | Function code of the strobed command |

## Verification
The hardest case to reach is a DONE rising edge that overwrites an interrupt latch which is already set. That needs a set latch, then a transfer started with IE deliberately written as 0, then a completion pulse.

The bench reaches this by first writing DONE and IE together, then issuing a transfer with IE low while DONE is still set. It then checks that the completion pulse drops `irq`. A second sequence clears IE after a latched completion to show that the request survives, while the attention-driven level request vanishes.

// File: rtl/stor_pkg.sv
package stor_pkg;
    localparam int DW       = 16;
    localparam int NB       = DW / 8;
    localparam int AE_W     = 6;
    localparam int UNIT_W   = 3;
    localparam int FN_W     = 5;
    localparam int ERR_W    = 8;
    localparam int AUXW     = 4;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_CNT  = 3'd1;
    localparam logic [2:0] RA_ADR  = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_DBUF = 3'd4;
    localparam logic [2:0] RA_AEXT = 3'd5;
    localparam logic [2:0] RA_AUX  = 3'd6;

    localparam int B_GO   = 0;
    localparam int B_IE   = 6;
    localparam int B_DONE = 7;
    localparam int B_TRE  = 14;
    localparam int B_CLR  = 5;
    localparam int E_MXF  = 1;
    localparam int E_PGE  = 2;
    localparam int E_NED  = 4;
    localparam int E_PE   = 5;

    typedef enum logic {ST_READY, ST_XFER} seq_state_e;
endpackage

// File: rtl/stor_datareg.sv
module stor_datareg #(
    parameter int W = 16,
    parameter logic [W-1:0] ZMASK = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [W/8-1:0] be,
    input  logic [W-1:0]   wd,
    output logic [W-1:0]   q
);
    localparam int LANES = W / 8;
    logic [W-1:0] merged;

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign merged[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : q[b*8 +: 8];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (we)     q <= merged & ~ZMASK;
    end
endmodule

// File: rtl/stor_seq.sv
module stor_seq
    import stor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic drv_done,
    input  logic drv_exc,
    output logic done,
    output logic busy,
    output logic finish,
    output logic fault
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        fault   = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (start) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (drv_exc) begin
                    fault   = 1'b1;
                    finish  = 1'b1;
                    state_d = ST_READY;
                end else if (drv_done) begin
                    finish  = 1'b1;
                    state_d = ST_READY;
                end
            end
        endcase
        if (clr) state_d = ST_READY;
    end

    assign done = (state_q == ST_READY);
    assign busy = (state_q == ST_XFER);
endmodule

// File: rtl/stor_irq.sv
module stor_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_wr,
    input  logic load,
    input  logic ie_now,
    input  logic level_req,
    output logic flop,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flop <= 1'b0;
        else if (clr)    flop <= 1'b0;
        else if (set_wr) flop <= 1'b1;
        else if (load)   flop <= ie_now;
    end

    assign irq = flop | level_req;
endmodule

// File: rtl/stor_adapter_csr.sv
module stor_adapter_csr
    import stor_pkg::*;
#(
    parameter int XFER_MIN = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [NB-1:0]     reg_be,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    input  logic              irq_ack,
    input  logic              drv_done,
    input  logic              drv_attn,
    input  logic              drv_exc,
    input  logic              drv_present,
    output logic [UNIT_W-1:0] drv_unit,
    output logic              cmd_go,
    output logic [FN_W-1:0]   cmd_fn
);
    logic [DW-1:0]     cnt_q, adr_q, dbuf_q;
    logic [AE_W-1:0]   ae_q;
    logic [ERR_W-1:0]  err_q;
    logic [UNIT_W-1:0] unit_q;
    logic [AUXW-1:0]   aux_q;
    logic              uai_q, pat_q, ie_q, tre_q;
    logic              done, busy, finish, fault, flop;

    logic wr_ctrl_lo, wr_ctrl_hi, wr_stat_lo, wr_stat_hi, wr_aux_lo, wr_aext_lo;
    logic go, is_xfer, pge_set, ned_set, accept, xfer_accept;
    logic soft_clr, tre_clr, err_any, tre_eff, sc, set_wr, irq_clr;
    logic [FN_W-1:0] fn;

    assign wr_ctrl_lo = reg_wr && reg_addr == RA_CTRL && reg_be[0];
    assign wr_ctrl_hi = reg_wr && reg_addr == RA_CTRL && reg_be[1];
    assign wr_stat_lo = reg_wr && reg_addr == RA_STAT && reg_be[0];
    assign wr_stat_hi = reg_wr && reg_addr == RA_STAT && reg_be[1];
    assign wr_aux_lo  = reg_wr && reg_addr == RA_AUX  && reg_be[0];
    assign wr_aext_lo = reg_wr && reg_addr == RA_AEXT && reg_be[0];

    assign fn          = reg_wdata[FN_W:1];
    assign go          = reg_wdata[B_GO];
    assign is_xfer     = go && (int'(fn) >= XFER_MIN);
    assign soft_clr    = wr_stat_lo && reg_wdata[B_CLR];
    assign pge_set     = wr_ctrl_lo && is_xfer && !done;
    assign ned_set     = wr_ctrl_lo && go && !pge_set && !drv_present;
    assign accept      = wr_ctrl_lo && go && !pge_set && drv_present;
    assign xfer_accept = accept && is_xfer;
    assign tre_clr     = wr_ctrl_hi && reg_wdata[B_TRE];
    assign set_wr      = wr_ctrl_lo && reg_wdata[B_DONE] && reg_wdata[B_IE];
    assign irq_clr     = soft_clr || irq_ack;

    assign err_any = |err_q;
    assign tre_eff = tre_q || err_any;
    assign sc      = tre_eff || drv_attn;

    stor_seq u_seq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .start(xfer_accept),
        .drv_done(drv_done), .drv_exc(drv_exc),
        .done(done), .busy(busy), .finish(finish), .fault(fault)
    );

    stor_irq u_irq (
        .clk(clk), .rst_n(rst_n), .clr(irq_clr), .set_wr(set_wr),
        .load(finish), .ie_now(ie_q), .level_req(sc && done && ie_q),
        .flop(flop), .irq(irq)
    );

    stor_datareg #(.W(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .we(reg_wr && reg_addr == RA_CNT), .be(reg_be), .wd(reg_wdata), .q(cnt_q)
    );
    stor_datareg #(.W(DW), .ZMASK(16'h0001)) u_adr (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .we(reg_wr && reg_addr == RA_ADR), .be(reg_be), .wd(reg_wdata), .q(adr_q)
    );
    stor_datareg #(.W(DW)) u_dbuf (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .we(reg_wr && reg_addr == RA_DBUF), .be(reg_be), .wd(reg_wdata), .q(dbuf_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            tre_q  <= 1'b0;
            err_q  <= '0;
            unit_q <= '0;
            uai_q  <= 1'b0;
            pat_q  <= 1'b0;
            aux_q  <= '0;
            ae_q   <= '0;
            cmd_go <= 1'b0;
            cmd_fn <= '0;
        end else if (soft_clr) begin
            ie_q   <= 1'b0;
            tre_q  <= 1'b0;
            err_q  <= '0;
            unit_q <= '0;
            uai_q  <= 1'b0;
            pat_q  <= 1'b0;
            aux_q  <= '0;
            ae_q   <= '0;
            cmd_go <= 1'b0;
            cmd_fn <= '0;
        end else begin
            cmd_go <= accept;
            if (accept) cmd_fn <= fn;

            if (irq_ack)         ie_q <= 1'b0;
            else if (wr_ctrl_lo) ie_q <= reg_wdata[B_IE];
            else if (wr_aux_lo)  ie_q <= reg_wdata[B_IE];

            if (wr_aux_lo) aux_q <= reg_wdata[AUXW-1:0];

            if (tre_clr || xfer_accept) tre_q <= 1'b0;
            else if (fault)             tre_q <= 1'b1;

            if (tre_clr || xfer_accept) begin
                err_q <= '0;
            end else begin
                if (wr_stat_hi) begin
                    err_q[E_MXF] <= reg_wdata[8 + E_MXF];
                    err_q[E_PE]  <= reg_wdata[8 + E_PE];
                end
                if (pge_set) err_q[E_PGE] <= 1'b1;
                if (ned_set) err_q[E_NED] <= 1'b1;
            end

            if (wr_stat_lo) begin
                unit_q <= reg_wdata[UNIT_W-1:0];
                uai_q  <= reg_wdata[3];
                pat_q  <= reg_wdata[4];
            end

            if (wr_aext_lo)             ae_q <= reg_wdata[AE_W-1:0];
            else if (wr_ctrl_hi && done) ae_q[1:0] <= reg_wdata[9:8];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {sc, tre_eff, 4'b0, ae_q[1:0], done, ie_q, 6'b0};
            RA_CNT:  reg_rdata = cnt_q;
            RA_ADR:  reg_rdata = adr_q;
            RA_STAT: reg_rdata = {err_q, 2'b11, 1'b0, pat_q, uai_q, unit_q};
            RA_DBUF: reg_rdata = dbuf_q;
            RA_AEXT: reg_rdata = {{(DW-AE_W){1'b0}}, ae_q};
            RA_AUX:  reg_rdata = {9'b0, ie_q, 2'b0, aux_q};
            default: reg_rdata = '0;
        endcase
    end

    assign drv_unit = unit_q;
endmodule

// File: rtl/stor_csr_checker.sv
module stor_csr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        irq_ack,
    input logic        done,
    input logic        busy,
    input logic        ie,
    input logic        flop,
    input logic        sc,
    input logic        err_any,
    input logic        tre_eff,
    input logic        err_pge,
    input logic        pge_set,
    input logic        set_wr,
    input logic        soft_clr,
    input logic        drv_done,
    input logic        drv_exc,
    input logic [2:0]  addr,
    input logic [15:0] rdata
);
    a_r5_level_term: assert property (@(posedge clk) disable iff (!rst_n)
        (sc && done && ie) |-> irq);
    a_r5_latch_term: assert property (@(posedge clk) disable iff (!rst_n)
        flop |-> irq);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!ie && !flop));
    a_r3_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (drv_done || drv_exc) && !irq_ack && !soft_clr && !set_wr)
        |=> (flop == $past(ie)));
    a_r14_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (drv_done || drv_exc)) |=> done);
    a_r8_pge: assert property (@(posedge clk) disable iff (!rst_n)
        (pge_set && !soft_clr) |=> err_pge);
    a_r6_forced: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> (tre_eff && sc));
    a_r12_adr_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2) |-> !rdata[0]);
endmodule

bind stor_adapter_csr stor_csr_checker i_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_ack(irq_ack), .done(done),
    .busy(busy), .ie(ie_q), .flop(flop), .sc(sc), .err_any(err_any),
    .tre_eff(tre_eff), .err_pge(err_q[2]), .pge_set(pge_set), .set_wr(set_wr),
    .soft_clr(soft_clr), .drv_done(drv_done), .drv_exc(drv_exc),
    .addr(reg_addr), .rdata(reg_rdata)
);

// File: tb/test_stor_adapter_csr.sv
module test_stor_adapter_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, irq_ack = 1'b0;
    logic        drv_done = 1'b0, drv_attn = 1'b0, drv_exc = 1'b0, drv_present = 1'b1;
    logic [2:0]  drv_unit;
    logic        cmd_go;
    logic [4:0]  cmd_fn;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stor_adapter_csr i_stor_adapter_csr (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .irq_ack(irq_ack), .drv_done(drv_done), .drv_attn(drv_attn),
        .drv_exc(drv_exc), .drv_present(drv_present), .drv_unit(drv_unit),
        .cmd_go(cmd_go), .cmd_fn(cmd_fn)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); drv_done = 1'b1;
        @(negedge clk); drv_done = 1'b0;
    endtask

    task automatic pulse_exc();
        @(negedge clk); drv_exc = 1'b1;
        @(negedge clk); drv_exc = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    initial begin
        #(20ns * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp_c, exp_d;
        do_reset();

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 16'h0080);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, (a == 3) ? 16'h00C0 : 16'h0000);
        end
        check("R1 irq", {15'b0, irq}, 16'h0);

        // R13 byte-lane merge sweep on count and data buffer
        exp_c = 16'h0; exp_d = 16'h0;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] val;
            logic [1:0]  be;
            val = 16'((i * 16'h1357) ^ 16'hA5C3);
            be  = 2'((i % 3) + 1);
            wr(3'd1, val, be);
            wr(3'd4, ~val, be);
            if (be[0]) begin exp_c[7:0]  = val[7:0];   exp_d[7:0]  = ~val[7:0];  end
            if (be[1]) begin exp_c[15:8] = val[15:8];  exp_d[15:8] = ~val[15:8]; end
            rd(3'd1, v); check("R13 count", v, exp_c);
            rd(3'd4, v); check("R13 dbuf", v, exp_d);
        end

        // R12 address bit 0
        wr(3'd2, 16'hFFFF, 2'b11);
        rd(3'd2, v); check("R12 full", v, 16'hFFFE);
        wr(3'd2, 16'h0001, 2'b01);
        rd(3'd2, v); check("R12 lane0 R13", v, 16'hFF00);

        // R2 DONE+IE write sets latch; R4 ack clears
        wr(3'd0, 16'h00C0, 2'b01);
        check("R2 irq", {15'b0, irq}, 16'h1);
        rd(3'd0, v); check("R2 ctrl", v, 16'h00C0);
        pulse_ack();
        check("R4 ack irq", {15'b0, irq}, 16'h0);
        rd(3'd0, v); check("R4 ack ie", v, 16'h0080);
        rd(3'd6, v); check("R4 ack aux", v, 16'h0000);

        // R10 IE mirror
        wr(3'd6, 16'h004F, 2'b11);
        rd(3'd0, v); check("R10 ctrl", v, 16'h00C0);
        rd(3'd6, v); check("R10 aux", v, 16'h004F);
        check("R5 no sc no irq", {15'b0, irq}, 16'h0);
        wr(3'd0, 16'h0000, 2'b01);
        rd(3'd6, v); check("R10 aux cleared", v, 16'h000F);

        // R8 / R14 / R3 transfer with IE set
        do_reset();
        wr(3'd0, 16'h0069, 2'b01);
        check("R8 cmd_go", {15'b0, cmd_go}, 16'h1);
        check("R8 cmd_fn", {11'b0, cmd_fn}, 16'd20);
        rd(3'd0, v); check("R8 busy ctrl", v, 16'h0040);
        pulse_done();
        rd(3'd0, v); check("R14 done back", v, 16'h00C0);
        check("R3 latch from ie", {15'b0, irq}, 16'h1);
        wr(3'd0, 16'h0000, 2'b01);
        check("R5 latch survives ie clear", {15'b0, irq}, 16'h1);
        pulse_ack();
        check("R4 ack drops", {15'b0, irq}, 16'h0);

        // R5 / R6 level term from attention
        do_reset();
        drv_attn = 1'b1;
        #1;
        rd(3'd0, v); check("R6 attn sc", v, 16'h8080);
        check("R5 ie off", {15'b0, irq}, 16'h0);
        wr(3'd6, 16'h0040, 2'b01);
        check("R5 level on", {15'b0, irq}, 16'h1);
        wr(3'd6, 16'h0000, 2'b01);
        check("R5 level off", {15'b0, irq}, 16'h0);
        drv_attn = 1'b0;

        // R3 DONE rise with IE=0 clears a set latch
        do_reset();
        wr(3'd0, 16'h00C0, 2'b01);
        wr(3'd0, 16'h0029, 2'b01);
        check("R3 latch held", {15'b0, irq}, 16'h1);
        rd(3'd0, v); check("R8 accepted", v, 16'h0000);
        pulse_done();
        check("R3 loads zero", {15'b0, irq}, 16'h0);
        rd(3'd0, v); check("R14 done", v, 16'h0080);

        // R8 program error, R14 exception, R6, R7
        do_reset();
        wr(3'd0, 16'h0029, 2'b01);
        wr(3'd0, 16'h0029, 2'b01);
        check("R8 no cmd when busy", {15'b0, cmd_go}, 16'h0);
        rd(3'd0, v); check("R6 pge forces", v, 16'hC000);
        rd(3'd3, v); check("R8 pge bit", v, 16'h04C0);
        pulse_exc();
        rd(3'd0, v); check("R14 exc", v, 16'hC080);
        check("R5 no irq ie0", {15'b0, irq}, 16'h0);
        wr(3'd0, 16'h4000, 2'b10);
        rd(3'd0, v); check("R7 tre clear", v, 16'h0080);
        rd(3'd3, v); check("R7 err clear", v, 16'h00C0);
        wr(3'd0, 16'h0029, 2'b01);
        pulse_exc();
        rd(3'd0, v); check("R14 exc latches tre", v, 16'hC080);
        rd(3'd3, v); check("R14 no status err", v, 16'h00C0);

        // R9 extension mirror and gating
        do_reset();
        wr(3'd5, 16'h003F, 2'b01);
        rd(3'd5, v); check("R9 aext", v, 16'h003F);
        rd(3'd0, v); check("R9 ctrl mirror", v, 16'h0380);
        wr(3'd0, 16'h0100, 2'b10);
        rd(3'd5, v); check("R9 ctrl write", v, 16'h003D);
        wr(3'd0, 16'h0029, 2'b01);
        wr(3'd0, 16'h0300, 2'b10);
        rd(3'd5, v); check("R9 gated busy", v, 16'h003D);
        rd(3'd0, v); check("R9 ctrl busy", v, 16'h0100);
        wr(3'd5, 16'hFF00, 2'b10);
        rd(3'd5, v); check("R9 hi lane ignored", v, 16'h003D);
        pulse_done();

        // R8 missing drive
        do_reset();
        drv_present = 1'b0;
        wr(3'd0, 16'h0003, 2'b01);
        check("R8 ned no cmd", {15'b0, cmd_go}, 16'h0);
        rd(3'd3, v); check("R8 ned bit", v, 16'h10C0);
        rd(3'd0, v); check("R6 ned forces", v, 16'hC080);
        drv_present = 1'b1;

        // R11 status fields and controller clear
        do_reset();
        for (int u = 0; u < 8; u++) begin
            wr(3'd3, 16'(u), 2'b01);
            rd(3'd3, v); check("R11 unit", v, 16'h00C0 | 16'(u));
            check("R11 unit out", {13'b0, drv_unit}, 16'(u));
        end
        wr(3'd3, 16'hFFDF, 2'b11);
        rd(3'd3, v); check("R11 writable", v, 16'h22DF);
        rd(3'd0, v); check("R6 written err", v, 16'hC080);
        wr(3'd1, 16'h1234, 2'b11);
        wr(3'd6, 16'h0040, 2'b01);
        wr(3'd0, 16'h00C0, 2'b01);
        wr(3'd3, 16'h0020, 2'b01);
        rd(3'd3, v); check("R11 clr stat", v, 16'h00C0);
        rd(3'd1, v); check("R11 clr count", v, 16'h0000);
        rd(3'd0, v); check("R4 clr ctrl", v, 16'h0080);
        rd(3'd6, v); check("R4 clr aux", v, 16'h0000);
        check("R4 clr irq", {15'b0, irq}, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule